// File: doc/BRIEF.md
# ECC-Protected Tag Matcher (Encode-and-Compare)

This block decides whether an incoming 4-bit lookup tag hits a stored entry that is held in memory as an 8-bit single-error-correcting, double-error-detecting codeword. It does not decode the stored word first. Instead it computes the check bits of the incoming tag with the same code and XORs the two codewords bit for bit. The XOR over the tag field runs from the raw incoming tag, in parallel with parity generation. Only the parity field has to wait for the encoder.

The resulting difference vector goes to a distance range detector. The detector resolves only whether the Hamming distance is zero, one, or two-or-more. A decision stage turns that range into three mutually exclusive flags. With the default configuration the flags are registered and qualified by a valid strobe. A parameter selects a purely combinational output instead. A cache-tag or translation-buffer lookup uses it this way: one stored codeword is presented together with the probe tag each cycle, and the flags are read back.

Top module: `tagcmp_matcher`

## Requirements
- R1: The codeword layout is systematic. Bits [3:0] hold tag bits d0..d3, and bits [7:4] hold check bits c0..c3, where c0 = d0^d1^d3, c1 = d0^d2^d3 and c2 = d1^d2^d3. A stored word built this way from the incoming tag compares at distance zero.
- R2: Check bit c3 (codeword bit 7) makes the whole 8-bit codeword even weight. A single flipped bit at any of the 8 positions, including bit 7, is therefore seen at distance one.
- R3: When the stored word and the encoded incoming tag are identical, `hit_exact` is 1.
- R4: When they differ in exactly one bit position, `hit_corr` is 1.
- R5: When they differ in two or more bit positions (up to all 8), `miss` is 1.
- R6: Whenever `out_valid` is 1, exactly one of `hit_exact`, `hit_corr` and `miss` is 1.
- R7: With REG_OUT=1, the result of a comparison with `in_valid` sampled high at a rising edge appears on the outputs right after that edge, with `out_valid` = 1. Back-to-back valid cycles each produce their own result.
- R8: A cycle with `in_valid` low gives `out_valid` = 0 and all three flags 0 after the next edge, whatever the tag and stored-word inputs are.
- R9: While `rst_n` is low, `out_valid` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| in_valid | input | 1 | Qualifies the tag and stored word this cycle |
| in_tag | input | 4 | Incoming probe tag |
| stored_cw | input | 8 | Stored codeword (check bits in [7:4], tag in [3:0]) |
| out_valid | output | 1 | Result flags are meaningful |
| hit_exact | output | 1 | Distance zero |
| hit_corr | output | 1 | Distance one: hit after single-bit correction |
| miss | output | 1 | Distance two or more: mismatch or uncorrectable |

## Verification
Each result is due one clock edge after its stimulus. Inputs are driven on a falling edge and take effect at the next rising edge. The bench samples `out_valid` and the flags at the following falling edge, exactly one register stage later. Every valid stimulus is checked in that window before the next stimulus's result lands, including during back-to-back runs. Idle cycles are checked in the same slot, with random tag and stored-word values still driven, to show they leave no result.

// File: rtl/tagcmp_pkg.sv
package tagcmp_pkg;
  localparam int TAG_W = 4;
  localparam int PAR_W = 4;
  localparam int CW_W  = TAG_W + PAR_W;

  typedef enum logic [1:0] {
    RNG_ZERO = 2'd0,
    RNG_ONE  = 2'd1,
    RNG_MANY = 2'd2
  } dist_rng_e;

  // Extended Hamming check bits: three Hamming bits, then overall parity.
  function automatic logic [PAR_W-1:0] ham_parity(input logic [TAG_W-1:0] d);
    logic [2:0] h;
    h[0] = d[0] ^ d[1] ^ d[3];
    h[1] = d[0] ^ d[2] ^ d[3];
    h[2] = d[1] ^ d[2] ^ d[3];
    return {^{h, d}, h};
  endfunction

  // Saturating one-or-more / two-or-more accumulation over the difference vector.
  function automatic dist_rng_e classify(input logic [CW_W-1:0] v);
    logic ge1, ge2;
    ge1 = 1'b0;
    ge2 = 1'b0;
    for (int i = 0; i < CW_W; i++) begin
      ge2 = ge2 | (ge1 & v[i]);
      ge1 = ge1 | v[i];
    end
    if (ge2)      return RNG_MANY;
    else if (ge1) return RNG_ONE;
    else          return RNG_ZERO;
  endfunction
endpackage

// File: rtl/tagcmp_parity_gen.sv
module tagcmp_parity_gen
  import tagcmp_pkg::*;
(
  input  logic [TAG_W-1:0] tag,
  output logic [PAR_W-1:0] par
);
  assign par = ham_parity(tag);

  // R2: every generated codeword has even weight.
  always_comb begin
    p_even_weight_r2: assert (^{par, tag} == 1'b0);
  end
endmodule

// File: rtl/tagcmp_xor_bank.sv
module tagcmp_xor_bank
  import tagcmp_pkg::*;
(
  input  logic [TAG_W-1:0] tag,
  input  logic [PAR_W-1:0] par,
  input  logic [CW_W-1:0]  stored,
  output logic [CW_W-1:0]  diff
);
  // Tag field is compared from the raw tag, independent of the encoder.
  for (genvar i = 0; i < TAG_W; i++) begin : g_data
    assign diff[i] = tag[i] ^ stored[i];
  end
  for (genvar j = 0; j < PAR_W; j++) begin : g_par
    assign diff[TAG_W+j] = par[j] ^ stored[TAG_W+j];
  end
endmodule

// File: rtl/tagcmp_range.sv
module tagcmp_range
  import tagcmp_pkg::*;
(
  input  logic [CW_W-1:0] diff,
  output dist_rng_e       rng
);
  assign rng = classify(diff);

  // R3/R4/R5: the range agrees with the population count of the difference.
  always_comb begin
    p_zero_range_r3: assert ((rng == RNG_ZERO) == (diff == '0));
    p_one_range_r4:  assert ((rng == RNG_ONE) == ($countones(diff) == 1));
    p_many_range_r5: assert ((rng == RNG_MANY) == ($countones(diff) >= 2));
  end
endmodule

// File: rtl/tagcmp_matcher.sv
module tagcmp_matcher
  import tagcmp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [CW_W-1:0]  stored_cw,
  output logic             out_valid,
  output logic             hit_exact,
  output logic             hit_corr,
  output logic             miss
);
  logic [PAR_W-1:0] enc_par;
  logic [CW_W-1:0]  diff_vec;
  dist_rng_e        rng;
  logic [2:0]       flags_next;

  tagcmp_parity_gen u_par (.tag(in_tag), .par(enc_par));
  tagcmp_xor_bank   u_xor (.tag(in_tag), .par(enc_par), .stored(stored_cw), .diff(diff_vec));
  tagcmp_range      u_rng (.diff(diff_vec), .rng(rng));

  always_comb begin
    flags_next = 3'b000;
    if (in_valid) begin
      unique case (rng)
        RNG_ZERO: flags_next = 3'b100;
        RNG_ONE:  flags_next = 3'b010;
        default:  flags_next = 3'b001;
      endcase
    end
  end

  if (REG_OUT) begin : g_reg
    logic       vld_q;
    logic [2:0] flg_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        flg_q <= 3'b000;
      end else begin
        vld_q <= in_valid;
        flg_q <= flags_next;
      end
    end
    assign out_valid = vld_q;
    assign {hit_exact, hit_corr, miss} = flg_q;

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !hit_exact && !hit_corr && !miss));
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones({hit_exact, hit_corr, miss}) == 1);
    p_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && stored_cw == {ham_parity(in_tag), in_tag}) |=> hit_exact);
  end else begin : g_comb
    assign out_valid = in_valid;
    assign {hit_exact, hit_corr, miss} = flags_next;
  end
endmodule

// File: tb/test_tagcmp_matcher.sv
module test_tagcmp_matcher;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] in_tag;
  logic [7:0] stored_cw;
  logic       out_valid, hit_exact, hit_corr, miss;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tagcmp_matcher i_tagcmp_matcher (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .stored_cw(stored_cw), .out_valid(out_valid), .hit_exact(hit_exact),
    .hit_corr(hit_corr), .miss(miss)
  );

  // Bench encoder: check bit k covers tag bits selected by a column mask.
  function automatic logic [7:0] bench_enc(input logic [3:0] t);
    logic [3:0] m [3] = '{4'b1011, 4'b1101, 4'b1110};
    logic [7:0] w;
    w = {4'b0000, t};
    for (int k = 0; k < 3; k++) w[4+k] = ^(t & m[k]);
    w[7] = ^w[6:0];
    return w;
  endfunction

  function automatic logic [3:0] bench_expect(input logic v, input logic [7:0] a, input logic [7:0] b);
    int d;
    if (!v) return 4'b0000;
    d = $countones(a ^ b);
    if (d == 0)      return 4'b1100;
    else if (d == 1) return 4'b1010;
    else             return 4'b1001;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,exact,corr,miss} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive on falling edge, result due right after the next rising edge.
  task automatic run(input string req, input logic v, input logic [3:0] t, input logic [7:0] cw);
    logic [3:0] exp;
    in_valid = v; in_tag = t; stored_cw = cw;
    exp = bench_expect(v, bench_enc(t), cw);
    @(posedge clk); @(negedge clk);
    check(req, {out_valid, hit_exact, hit_corr, miss}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; in_valid = 1'b1; in_tag = 4'h3; stored_cw = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 reset", {out_valid, hit_exact, hit_corr, miss}, 4'b0000);
    rst_n = 1'b1;

    for (int t = 0; t < 16; t++) begin
      logic [7:0] cw;
      cw = bench_enc(4'(t));
      run("R1 R3 exact", 1'b1, 4'(t), cw);
      for (int b = 0; b < 8; b++)
        run("R2 R4 single flip", 1'b1, 4'(t), cw ^ (8'h01 << b));
      begin
        int a, c;
        a = $urandom_range(7); c = (a + 1 + $urandom_range(6)) % 8;
        run("R5 double flip", 1'b1, 4'(t), cw ^ (8'h01 << a) ^ (8'h01 << c));
      end
      run("R5 all flipped", 1'b1, 4'(t), ~cw);
    end

    // Stored word for a different tag.
    run("R5 other tag", 1'b1, 4'h0, bench_enc(4'h1));
    run("R6 mixed random", 1'b1, 4'hA, 8'h5C);

    // Idle cycles must leave no result.
    for (int i = 0; i < 20; i++)
      run("R8 idle", 1'b0, 4'($urandom), 8'($urandom));

    // Random back-to-back traffic with occasional idles.
    for (int i = 0; i < 400; i++) begin
      logic [3:0] t;
      logic [7:0] cw;
      int mode;
      t = 4'($urandom);
      mode = $urandom_range(3);
      if (mode == 0)      cw = bench_enc(t);
      else if (mode == 1) cw = bench_enc(t) ^ (8'h01 << $urandom_range(7));
      else                cw = 8'($urandom);
      run("R6 R7 random", ($urandom_range(7) != 0), t, cw);
    end

    // Reset mid-stream clears a pending result.
    in_valid = 1'b1; in_tag = 4'h7; stored_cw = bench_enc(4'h7); rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 reset mid-run", {out_valid, hit_exact, hit_corr, miss}, 4'b0000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule